// File: doc/BRIEF.md
# Circular Seek Position Tracker

This block holds a position on a ring of 2^POS_W values (256 at the default width) and moves it one count toward a target on every clock edge where stepping is enabled. It always travels along the shorter of the two arcs. The position then wraps at the ends of the range instead of stopping there. A typical use is a rotary pointer, such as a phase index, a ring-buffer head or a motor commutation counter, that has to chase a moving setpoint without ever taking the long way round.

The direction is chosen from one number: the unsigned difference target minus position, taken modulo the ring size. A difference below half the ring means the target lies ahead, so the block counts up. A difference of half the ring or more means the target lies behind, so the block counts down. At exactly half the ring the two arcs have equal length, and the block counts down. A load port writes the position directly and takes priority over stepping. The direction output is registered with the move it describes. The at-target flag compares the position register with the target that is currently applied.

Top module: `circ_seek`

## Requirements
- R1: While `rst` is high at a clock edge, `pos` becomes 0 and `dir_up` becomes 0 after that edge.
- R2: On an edge where `step_en` and `load_en` are both low, `pos` and `dir_up` do not change.
- R3: When `pos` equals `target`, `at_target` is 1 in that same cycle. An enabled step on such an edge leaves `pos` and `dir_up` unchanged.
- R4: With d = (target - pos) mod 2^POS_W and 1 <= d < 2^(POS_W-1), an enabled step increments `pos` by one, and 255 wraps to 0 at the default width.
- R5: With d >= 2^(POS_W-1), an enabled step decrements `pos` by one, and 0 wraps to 255 at the default width.
- R6: With d exactly 2^(POS_W-1) (128 at the default width), the step is a decrement.
- R7: When `load_en` is high at an edge, `pos` takes `load_val` whatever the value of `step_en`, and `dir_up` is held.
- R8: After every edge that moves `pos`, `dir_up` is 1 if that move was an increment and 0 if it was a decrement.
- R9: With a fixed target and no load, `pos` reaches the target after at most 2^(POS_W-1) enabled steps, from any start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Allow one step toward the target on this edge |
| load_en | input | 1 | Write `load_val` into the position; has priority over stepping |
| load_val | input | POS_W | Value loaded into the position |
| target | input | POS_W | Position to seek |
| pos | output | POS_W | Current position (registered) |
| dir_up | output | 1 | Direction of the last move: 1 for up, 0 for down (registered) |
| at_target | output | 1 | High while `pos` equals `target` |

## Verification
The hardest case to reach is the tie at a wrapped difference of exactly half the ring, together with the wrap of the position across 0 and 255. Stepping from reset seldom lands on these points. The stimulus therefore uses the load port to place the position directly at a chosen spot, and then applies one step against a chosen target. This covers both ends of the wrap and the tie, including a tie where the target is numerically below the position. The worst-case convergence starts a full half ring away, then steps until the flag rises and counts the steps taken.

// File: rtl/circ_seek_pkg.sv
package circ_seek_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } seek_dir_e;
endpackage

// File: rtl/circ_seek_dir.sv
// Chooses the direction of the shorter arc from one wrapped difference.
module circ_seek_dir
  import circ_seek_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] cur,
  input  logic [POS_W-1:0] tgt,
  output logic             hit,
  output seek_dir_e        dir
);
  localparam logic [POS_W-1:0] HALF = {1'b1, {(POS_W-1){1'b0}}};

  logic [POS_W-1:0] gap;

  always_comb begin
    gap = tgt - cur;                 // modulo 2^POS_W by width
    hit = (gap == '0);
    dir = (gap < HALF) ? DIR_UP : DIR_DOWN;  // tie at HALF goes down
  end
endmodule

// File: rtl/circ_seek_stepper.sv
// Position and direction registers; load beats step.
module circ_seek_stepper
  import circ_seek_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic             step_en,
  input  logic             hit,
  input  seek_dir_e        dir,
  output logic [POS_W-1:0] pos_q,
  output seek_dir_e        dir_q
);
  localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

  logic [POS_W-1:0] pos_step;

  always_comb begin
    pos_step = (dir == DIR_UP) ? pos_q + ONE : pos_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (load_en) begin
      pos_q <= load_val;
    end else if (step_en && !hit) begin
      pos_q <= pos_step;
      dir_q <= dir;
    end
  end
endmodule

// File: rtl/circ_seek.sv
module circ_seek
  import circ_seek_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic [POS_W-1:0] target,
  output logic [POS_W-1:0] pos,
  output logic             dir_up,
  output logic             at_target
);
  logic             hit;
  seek_dir_e        dir_now;
  seek_dir_e        dir_reg;
  logic [POS_W-1:0] pos_reg;

  circ_seek_dir #(.POS_W(POS_W)) u_dir (
    .cur (pos_reg),
    .tgt (target),
    .hit (hit),
    .dir (dir_now)
  );

  circ_seek_stepper #(.POS_W(POS_W)) u_step (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .step_en  (step_en),
    .hit      (hit),
    .dir      (dir_now),
    .pos_q    (pos_reg),
    .dir_q    (dir_reg)
  );

  assign pos       = pos_reg;
  assign dir_up    = (dir_reg == DIR_UP);
  assign at_target = hit;
endmodule

// File: rtl/circ_seek_chk.sv
module circ_seek_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             step_en,
  input logic             load_en,
  input logic [POS_W-1:0] load_val,
  input logic [POS_W-1:0] target,
  input logic [POS_W-1:0] pos,
  input logic             dir_up,
  input logic             at_target
);
  localparam int HALF = 2 ** (POS_W - 1);

  logic [POS_W-1:0] gap;
  assign gap = target - pos;

  logic             seen_rst;
  logic [POS_W-1:0] tgt_prev;
  int unsigned      moves;

  always_ff @(posedge clk) begin
    tgt_prev <= target;
    if (rst) begin
      seen_rst <= 1'b1;
      moves    <= 0;
    end else if (load_en || at_target || target != tgt_prev) begin
      moves <= 0;
    end else if (step_en) begin
      moves <= moves + 1;
    end
  end

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (pos == '0) && !dir_up);

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> ($stable(pos) && $stable(dir_up)));

  a_r3_park: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && at_target) |=> ($stable(pos) && $stable(dir_up)));

  a_r4_up: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && gap != '0 && int'(gap) < HALF)
      |=> (pos == $past(pos) + 1'b1) && dir_up);

  a_r5_down: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && int'(gap) >= HALF)
      |=> (pos == $past(pos) - 1'b1) && !dir_up);

  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (pos == $past(load_val)) && $stable(dir_up));

  a_r9_bound: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    moves <= HALF);
endmodule

bind circ_seek circ_seek_chk #(.POS_W(POS_W)) u_chk (.*);

// File: tb/circ_seek_test.sv
`timescale 1ns/1ps
module circ_seek_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] target = '0;
  logic [W-1:0] pos;
  logic         dir_up;
  logic         at_target;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  circ_seek #(.POS_W(W)) uut (
    .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
    .load_val(load_val), .target(target), .pos(pos),
    .dir_up(dir_up), .at_target(at_target)
  );

  // {start, target, expected pos after one step, expected dir_up}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {8'd10,  8'd20,  8'd11,  1'b1},
    {8'd20,  8'd10,  8'd19,  1'b0},
    {8'd255, 8'd5,   8'd0,   1'b1},
    {8'd0,   8'd250, 8'd255, 1'b0},
    {8'd0,   8'd128, 8'd255, 1'b0},
    {8'd0,   8'd127, 8'd1,   1'b1},
    {8'd200, 8'd72,  8'd199, 1'b0},
    {8'd5,   8'd4,   8'd4,   1'b0},
    {8'd130, 8'd2,   8'd129, 1'b0},
    {8'd4,   8'd5,   8'd5,   1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic load_at(input logic [W-1:0] p, input logic [W-1:0] t);
    @(negedge clk);
    load_en = 1'b1; load_val = p; target = t; step_en = 1'b0;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    target = 8'd40;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset pos", int'(pos), 0);
    check("R1 reset dir", int'(dir_up), 0);

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] p, t, e, gap;
      logic d;
      string tag;
      {p, t, e, d} = VEC[i];
      gap = t - p;
      tag = (gap == 8'd128) ? "R6" : (d ? "R4" : "R5");
      load_at(p, t);
      check("R7 load", int'(pos), int'(p));
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
      check({tag, " pos"}, int'(pos), int'(e));
      check({"R8 dir ", tag}, int'(dir_up), int'(d));
    end

    // R3: at target, a step leaves everything alone (last move was up)
    load_at(8'd77, 8'd77);
    check("R3 flag", int'(at_target), 1);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check("R3 pos", int'(pos), 77);
    check("R3 dir", int'(dir_up), 1);

    // R2: no enable, no movement
    load_at(8'd30, 8'd60);
    repeat (3) @(negedge clk);
    check("R2 pos", int'(pos), 30);
    check("R2 flag", int'(at_target), 0);

    // R7: load wins over step in the same cycle
    load_at(8'd50, 8'd60);
    @(negedge clk);
    load_en = 1'b1; load_val = 8'd9; target = 8'd200; step_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    check("R7 override pos", int'(pos), 9);

    // R9: worst case half ring away
    begin
      int steps = 0;
      load_at(8'd0, 8'd128);
      step_en = 1'b1;
      while (!at_target && steps < 300) begin
        @(negedge clk);
        steps++;
      end
      step_en = 1'b0;
      check("R9 steps", steps, 128);
      check("R9 pos", int'(pos), 128);
      check("R9 dir", int'(dir_up), 0);
    end

    // R1 mid-run reset
    load_at(8'd99, 8'd3);
    rst = 1'b1; step_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; step_en = 1'b0;
    check("R1 mid reset pos", int'(pos), 0);
    check("R1 mid reset dir", int'(dir_up), 0);

    finish_run();
  end
endmodule